// File: doc/BRIEF.md
# In-Place Increment Memory Engine

This block is a memory-mapped master core that rewrites one region of memory in place. A single-cycle start pulse, sampled together with a 64-bit base address, launches a run. The engine reads a 16 KB window starting at that base in 64-byte beats. It adds one to every 32-bit lane of every beat and writes each result back to the address it was read from. It reports completion once every write burst has been acknowledged.

All traffic uses a single transaction ID and only incrementing full-width bursts. Each burst moves exactly 4 KB, so it never crosses a 4 KB boundary. A small on-chip store of whole bursts (two by default) sits between the read and write sides. A read burst is requested only when a free slot for all of its beats exists. A write burst is requested only after all of its data has arrived. As a result, the read-data and write-data channels never stall on the engine's side, and reads of later bursts overlap the write-back of earlier ones.

Top module: `inc_mem_engine`

## Requirements
- R1: After reset, idle is 1, done is 0, err is 0, and the read-address, write-address and write-data valid outputs are all 0.
- R2: Every read and every write address request uses burst type code 01 (incrementing), length field 63 (64 beats) and size code 6 (64 bytes). Burst k of a run, for k = 0 to 3, uses address base + k*4096 on both channels, in ascending order. A request that is not yet accepted keeps its valid and address unchanged.
- R3: Every write beat carries an all-ones 64-bit strobe. The last flag is set on the 64th beat of each burst and on no other beat.
- R4: Each 32-bit lane of a written beat equals the same lane of the beat read from that address, plus one modulo 2^32 (FFFFFFFF becomes 00000000). After a run, the whole 16 KB window holds the incremented values.
- R5: A read request is made only while fewer than 2 bursts are read-requested but not yet fully sent as write data.
- R6: The write request for burst k is made only after all 64 read beats of burst k have been received.
- R7: Reads are pipelined. When read data is delayed, a second read request is accepted before the first read beat arrives.
- R8: done is a one-cycle pulse that appears in the cycle after the handshake of the fourth and final write response. It appears exactly once per run.
- R9: idle falls in the cycle after an accepted start and stays low until done. A start pulse while a run is active is ignored and does not change the base address in use.
- R10: err is set by any read or write response code other than 00. It stays set until the next accepted start, and is 0 in the cycle after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| base_addr | input | 64 | 4 KB-aligned base of the window, sampled with start |
| done | output | 1 | One-cycle completion pulse |
| idle | output | 1 | High when no run is active |
| err | output | 1 | Sticky flag for a non-OKAY response |
| m_araddr | output | 64 | Read burst address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 512 | Read data beat |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Final read beat of a burst |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | 64 | Write burst address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 512 | Write data beat |
| m_wstrb | output | 64 | Write byte strobes |
| m_wlast | output | 1 | Final write beat of a burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
done is due one cycle after the final write-response handshake. idle falls one cycle after the accepting edge, and err moves one cycle after the offending beat or after the next accepted start. Channel ordering results (addresses, beat counts, buffer occupancy) are recorded by bench monitors at the edge where each handshake occurs, using the same edge the design sees. Level results such as done, idle and err are read at the falling edge that follows, which is the first point where the registered value is settled.

// File: rtl/inc_eng_pkg.sv
package inc_eng_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned BUS_W  = 512;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned LANES  = BUS_W / LANE_W;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  // Add one to every lane, each lane wrapping on its own.
  function automatic logic [BUS_W-1:0] lanes_plus_one(input logic [BUS_W-1:0] beat);
    logic [BUS_W-1:0] res;
    for (int l = 0; l < LANES; l++)
      res[l*LANE_W +: LANE_W] = beat[l*LANE_W +: LANE_W] + LANE_W'(1);
    return res;
  endfunction

  // Address of burst number idx within a run.
  function automatic logic [ADDR_W-1:0] burst_addr(input logic [ADDR_W-1:0] base,
                                                   input int unsigned idx,
                                                   input int unsigned burst_bytes);
    return base + ADDR_W'(idx) * ADDR_W'(burst_bytes);
  endfunction
endpackage

// File: rtl/inc_slot_buf.sv
module inc_slot_buf import inc_eng_pkg::*; #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [BUS_W-1:0] rdata
);
  logic [BUS_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/inc_rd_ctrl.sv
module inc_rd_ctrl import inc_eng_pkg::*; #(
  parameter int unsigned BURST_LEN  = 64,
  parameter int unsigned NUM_BURSTS = 4,
  parameter int unsigned SLOTS      = 2,
  localparam int unsigned CNT_W  = $clog2(NUM_BURSTS + 1),
  localparam int unsigned BEAT_W = $clog2(BURST_LEN),
  localparam int unsigned IDX_W  = $clog2(SLOTS * BURST_LEN),
  localparam int unsigned BURST_BYTES = BURST_LEN * (BUS_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              busy,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  drained,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  input  logic              r_valid,
  input  logic [BUS_W-1:0]  r_data,
  input  logic [1:0]        r_resp,
  input  logic              r_last,
  output logic              r_ready,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_waddr,
  output logic [BUS_W-1:0]  buf_wdata,
  output logic [CNT_W-1:0]  filled,
  output logic              ar_fire,
  output logic              fill_evt,
  output logic              r_err_evt
);
  logic [CNT_W-1:0]  issued_q, filled_q, in_flight;
  logic [BEAT_W-1:0] beat_q;
  logic [IDX_W-1:0]  slot_base_q;
  logic              r_fire;

  assign in_flight = issued_q - drained;
  assign ar_valid  = busy && (int'(issued_q) < int'(NUM_BURSTS)) && (int'(in_flight) < int'(SLOTS));
  assign ar_addr   = burst_addr(base, int'(issued_q), BURST_BYTES);
  assign ar_fire   = ar_valid && ar_ready;

  assign r_ready   = busy;
  assign r_fire    = r_valid && r_ready;
  assign fill_evt  = r_fire && r_last;
  assign r_err_evt = r_fire && (r_resp != RESP_OKAY);

  assign buf_we    = r_fire;
  assign buf_waddr = slot_base_q + IDX_W'(beat_q);
  assign buf_wdata = lanes_plus_one(r_data);
  assign filled    = filled_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      issued_q    <= '0;
      filled_q    <= '0;
      beat_q      <= '0;
      slot_base_q <= '0;
    end else begin
      if (ar_fire) issued_q <= issued_q + 1'b1;
      if (r_fire) beat_q <= r_last ? '0 : beat_q + 1'b1;
      if (fill_evt) begin
        filled_q    <= filled_q + 1'b1;
        slot_base_q <= (slot_base_q == IDX_W'((SLOTS - 1) * BURST_LEN)) ? '0
                       : slot_base_q + IDX_W'(BURST_LEN);
      end
    end
  end
endmodule

// File: rtl/inc_wr_ctrl.sv
module inc_wr_ctrl import inc_eng_pkg::*; #(
  parameter int unsigned BURST_LEN  = 64,
  parameter int unsigned NUM_BURSTS = 4,
  parameter int unsigned SLOTS      = 2,
  localparam int unsigned CNT_W  = $clog2(NUM_BURSTS + 1),
  localparam int unsigned BEAT_W = $clog2(BURST_LEN),
  localparam int unsigned IDX_W  = $clog2(SLOTS * BURST_LEN),
  localparam int unsigned BURST_BYTES = BURST_LEN * (BUS_W / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               busy,
  input  logic [ADDR_W-1:0]  base,
  input  logic [CNT_W-1:0]   filled,
  output logic               aw_valid,
  input  logic               aw_ready,
  output logic [ADDR_W-1:0]  aw_addr,
  output logic               w_valid,
  input  logic               w_ready,
  output logic               w_last,
  output logic [BUS_W/8-1:0] w_strb,
  output logic [BUS_W-1:0]   w_data,
  output logic [IDX_W-1:0]   buf_raddr,
  input  logic [BUS_W-1:0]   buf_rdata,
  input  logic               b_valid,
  input  logic [1:0]         b_resp,
  output logic               b_ready,
  output logic [CNT_W-1:0]   drained,
  output logic               aw_fire,
  output logic               w_fire,
  output logic               drain_evt,
  output logic               final_evt,
  output logic               b_err_evt
);
  logic [CNT_W-1:0]  aw_issued_q, drained_q, b_cnt_q;
  logic [BEAT_W-1:0] beat_q;
  logic [IDX_W-1:0]  slot_base_q;
  logic              b_fire;

  assign aw_valid  = busy && (aw_issued_q < filled);
  assign aw_addr   = burst_addr(base, int'(aw_issued_q), BURST_BYTES);
  assign aw_fire   = aw_valid && aw_ready;

  assign w_valid   = busy && (drained_q < aw_issued_q);
  assign w_last    = (beat_q == BEAT_W'(BURST_LEN - 1));
  assign w_strb    = '1;
  assign buf_raddr = slot_base_q + IDX_W'(beat_q);
  assign w_data    = buf_rdata;
  assign w_fire    = w_valid && w_ready;
  assign drain_evt = w_fire && w_last;
  assign drained   = drained_q;

  assign b_ready   = busy;
  assign b_fire    = b_valid && b_ready;
  assign final_evt = b_fire && (b_cnt_q == CNT_W'(NUM_BURSTS - 1));
  assign b_err_evt = b_fire && (b_resp != RESP_OKAY);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      aw_issued_q <= '0;
      drained_q   <= '0;
      b_cnt_q     <= '0;
      beat_q      <= '0;
      slot_base_q <= '0;
    end else begin
      if (aw_fire) aw_issued_q <= aw_issued_q + 1'b1;
      if (w_fire) beat_q <= w_last ? '0 : beat_q + 1'b1;
      if (drain_evt) begin
        drained_q   <= drained_q + 1'b1;
        slot_base_q <= (slot_base_q == IDX_W'((SLOTS - 1) * BURST_LEN)) ? '0
                       : slot_base_q + IDX_W'(BURST_LEN);
      end
      if (b_fire) b_cnt_q <= b_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/inc_mem_engine.sv
module inc_mem_engine import inc_eng_pkg::*; #(
  parameter int unsigned BURST_LEN  = 64,
  parameter int unsigned NUM_BURSTS = 4,
  parameter int unsigned SLOTS      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [63:0]        base_addr,
  output logic               done,
  output logic               idle,
  output logic               err,
  output logic [63:0]        m_araddr,
  output logic [7:0]         m_arlen,
  output logic [2:0]         m_arsize,
  output logic [1:0]         m_arburst,
  output logic               m_arvalid,
  input  logic               m_arready,
  input  logic [511:0]       m_rdata,
  input  logic [1:0]         m_rresp,
  input  logic               m_rlast,
  input  logic               m_rvalid,
  output logic               m_rready,
  output logic [63:0]        m_awaddr,
  output logic [7:0]         m_awlen,
  output logic [2:0]         m_awsize,
  output logic [1:0]         m_awburst,
  output logic               m_awvalid,
  input  logic               m_awready,
  output logic [511:0]       m_wdata,
  output logic [63:0]        m_wstrb,
  output logic               m_wlast,
  output logic               m_wvalid,
  input  logic               m_wready,
  input  logic [1:0]         m_bresp,
  input  logic               m_bvalid,
  output logic               m_bready
);
  localparam int unsigned SIZE_CODE = $clog2(BUS_W / 8);
  localparam int unsigned CNT_W     = $clog2(NUM_BURSTS + 1);
  localparam int unsigned IDX_W     = $clog2(SLOTS * BURST_LEN);

  logic              busy_q, done_q, err_q;
  logic [ADDR_W-1:0] base_q;
  logic              start_acc;
  logic [CNT_W-1:0]  filled, drained;
  logic              buf_we;
  logic [IDX_W-1:0]  buf_waddr, buf_raddr;
  logic [BUS_W-1:0]  buf_wdata, buf_rdata;
  // Named events, also observed by the bound checker
  logic ar_fire, fill_evt, r_err_evt, aw_fire, w_fire, drain_evt, final_evt, b_err_evt;

  assign start_acc = start && !busy_q;

  assign m_arlen   = 8'(BURST_LEN - 1);
  assign m_awlen   = 8'(BURST_LEN - 1);
  assign m_arsize  = 3'(SIZE_CODE);
  assign m_awsize  = 3'(SIZE_CODE);
  assign m_arburst = BURST_INCR;
  assign m_awburst = BURST_INCR;

  inc_rd_ctrl #(.BURST_LEN(BURST_LEN), .NUM_BURSTS(NUM_BURSTS), .SLOTS(SLOTS)) rd_i (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .busy(busy_q), .base(base_q),
    .drained(drained),
    .ar_valid(m_arvalid), .ar_ready(m_arready), .ar_addr(m_araddr),
    .r_valid(m_rvalid), .r_data(m_rdata), .r_resp(m_rresp), .r_last(m_rlast),
    .r_ready(m_rready),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .filled(filled), .ar_fire(ar_fire), .fill_evt(fill_evt), .r_err_evt(r_err_evt)
  );

  inc_slot_buf #(.DEPTH(SLOTS * BURST_LEN)) buf_i (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  inc_wr_ctrl #(.BURST_LEN(BURST_LEN), .NUM_BURSTS(NUM_BURSTS), .SLOTS(SLOTS)) wr_i (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .busy(busy_q), .base(base_q),
    .filled(filled),
    .aw_valid(m_awvalid), .aw_ready(m_awready), .aw_addr(m_awaddr),
    .w_valid(m_wvalid), .w_ready(m_wready), .w_last(m_wlast), .w_strb(m_wstrb),
    .w_data(m_wdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .b_valid(m_bvalid), .b_resp(m_bresp), .b_ready(m_bready),
    .drained(drained), .aw_fire(aw_fire), .w_fire(w_fire), .drain_evt(drain_evt),
    .final_evt(final_evt), .b_err_evt(b_err_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
    end else begin
      done_q <= final_evt;
      if (start_acc) begin
        busy_q <= 1'b1;
        base_q <= base_addr;
        err_q  <= 1'b0;
      end else begin
        if (final_evt) busy_q <= 1'b0;
        if (r_err_evt || b_err_evt) err_q <= 1'b1;
      end
    end
  end

  assign done = done_q;
  assign idle = !busy_q;
  assign err  = err_q;
endmodule

// File: rtl/inc_eng_chk.sv
module inc_eng_chk #(
  parameter int unsigned BURST_LEN = 64,
  parameter int unsigned SLOTS     = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        idle,
  input logic        done,
  input logic        err,
  input logic        m_arvalid,
  input logic        m_arready,
  input logic [63:0] m_araddr,
  input logic        m_awvalid,
  input logic        m_awready,
  input logic [63:0] m_awaddr,
  input logic        m_wlast,
  input logic        ar_fire,
  input logic        aw_fire,
  input logic        w_fire,
  input logic        fill_evt,
  input logic        drain_evt,
  input logic        final_evt
);
  int unsigned ar_n, aw_n, fill_n, drn_n, wbeat_n;

  always_ff @(posedge clk) begin
    if (!rst_n || (start && idle)) begin
      ar_n <= 0; aw_n <= 0; fill_n <= 0; drn_n <= 0; wbeat_n <= 0;
    end else begin
      if (ar_fire)   ar_n   <= ar_n + 1;
      if (aw_fire)   aw_n   <= aw_n + 1;
      if (fill_evt)  fill_n <= fill_n + 1;
      if (drain_evt) drn_n  <= drn_n + 1;
      if (w_fire)    wbeat_n <= m_wlast ? 0 : wbeat_n + 1;
    end
  end

  assert_ar_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));
  assert_aw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
  assert_wlast_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    w_fire |-> (m_wlast == (wbeat_n == BURST_LEN - 1)));
  assert_ar_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |-> (ar_n - drn_n) < SLOTS);
  assert_aw_filled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire |-> aw_n < fill_n);
  assert_done_after_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(final_evt));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_falls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start && idle |=> !idle);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(start && idle) |=> err);
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && idle |=> !err);
endmodule

bind inc_mem_engine inc_eng_chk #(.BURST_LEN(BURST_LEN), .SLOTS(SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .idle(idle), .done(done), .err(err),
  .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
  .m_wlast(m_wlast), .ar_fire(ar_fire), .aw_fire(aw_fire), .w_fire(w_fire),
  .fill_evt(fill_evt), .drain_evt(drain_evt), .final_evt(final_evt)
);

// File: tb/inc_mem_engine_tb_top.sv
module inc_mem_engine_tb_top;
  typedef struct packed {
    logic [63:0] base;
    logic [31:0] seed;
    logic [3:0]  thr;
    logic [7:0]  rdelay;
    logic [2:0]  rerr;
    logic [2:0]  berr;
    logic        poke;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0001_0000_0000, 32'h1000_0000, 4'd0, 8'd0,  3'd7, 3'd7, 1'b0},
    '{64'h0000_0000_8000_3000, 32'hFFFF_FFF0, 4'd3, 8'd2,  3'd7, 3'd7, 1'b1},
    '{64'hFFFF_FFFF_FFFF_0000, 32'h0000_0000, 4'd2, 8'd30, 3'd2, 3'd7, 1'b0},
    '{64'h0000_0000_0000_1000, 32'hDEAD_0000, 4'd0, 8'd0,  3'd7, 3'd3, 1'b0},
    '{64'h0000_0000_2000_0000, 32'h5555_5555, 4'd5, 8'd1,  3'd7, 3'd7, 1'b0}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [63:0] base_addr = '0;
  logic done, idle, err;
  logic [63:0] m_araddr, m_awaddr;
  logic [7:0] m_arlen, m_awlen;
  logic [2:0] m_arsize, m_awsize;
  logic [1:0] m_arburst, m_awburst;
  logic m_arvalid, m_awvalid, m_rready, m_wvalid, m_wlast, m_bready;
  logic [511:0] m_wdata;
  logic [63:0] m_wstrb;
  logic s_arready = 0, s_rvalid = 0, s_rlast = 0, s_awready = 0, s_wready = 0, s_bvalid = 0;
  logic [511:0] s_rdata = '0;
  logic [1:0] s_rresp = 0, s_bresp = 0;

  always #5 clk = ~clk;

  inc_mem_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .done(done), .idle(idle), .err(err),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .m_arvalid(m_arvalid), .m_arready(s_arready),
    .m_rdata(s_rdata), .m_rresp(s_rresp), .m_rlast(s_rlast), .m_rvalid(s_rvalid),
    .m_rready(m_rready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(s_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid),
    .m_wready(s_wready),
    .m_bresp(s_bresp), .m_bvalid(s_bvalid), .m_bready(m_bready)
  );

  logic [511:0] mem [256];
  logic [511:0] orig [256];
  logic [63:0] cur_base = '0;
  int cfg_thr = 0, cfg_rdelay = 0, cfg_rerr = 7, cfg_berr = 7;
  int ar_n = 0, aw_n = 0, rd_done = 0, w_done = 0, b_n = 0;
  int ar_bad = 0, aw_bad = 0, w_bad = 0, r5_bad = 0, r6_bad = 0, ar_before_r = 0;
  bit seen_r = 0, in_run = 0, finished = 0, prev_err = 0;
  int last_b_cyc = 0, done_cyc = 0, done_cnt = 0, idle_bad = 0, cyc = 0;
  logic [63:0] arq_a [8];
  int arq_t [8];
  int arq_wp = 0, arq_rp = 0, rbeat = 0;
  logic [63:0] awq [8];
  int awq_wp = 0, awq_rp = 0, wbeat = 0, bpend = 0;
  int n_checks = 0, n_errs = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Read side of the memory model
  initial begin
    int idx;
    forever begin
      @(posedge clk);
      if (rst_n) begin
        if (m_arvalid && s_arready) begin
          if (m_arburst != 2'b01 || m_arlen != 8'd63 || m_arsize != 3'd6 ||
              m_araddr != cur_base + 64'(ar_n) * 64'd4096) ar_bad++;
          if (ar_n - w_done >= 2) r5_bad++;
          if (!seen_r) ar_before_r++;
          arq_a[arq_wp % 8] = m_araddr;
          arq_t[arq_wp % 8] = cyc;
          arq_wp++;
          ar_n++;
        end
        if (s_rvalid && m_rready) begin
          seen_r = 1;
          if (s_rlast) begin arq_rp++; rbeat = 0; rd_done++; end
          else rbeat++;
        end
      end
      if (arq_rp != arq_wp && (cyc - arq_t[arq_rp % 8]) >= cfg_rdelay) begin
        idx = (int'((arq_a[arq_rp % 8] - cur_base) >> 6) + rbeat) & 255;
        s_rvalid <= 1'b1;
        s_rdata  <= mem[idx];
        s_rlast  <= (rbeat == 63);
        s_rresp  <= (rd_done == cfg_rerr) ? 2'b10 : 2'b00;
      end else begin
        s_rvalid <= 1'b0;
        s_rlast  <= 1'b0;
      end
      s_arready <= (cfg_thr == 0) || (cyc % 2 == 0);
    end
  end

  // Write side of the memory model
  initial begin
    int idx;
    forever begin
      @(posedge clk);
      if (rst_n) begin
        if (m_awvalid && s_awready) begin
          if (m_awburst != 2'b01 || m_awlen != 8'd63 || m_awsize != 3'd6 ||
              m_awaddr != cur_base + 64'(aw_n) * 64'd4096) aw_bad++;
          if (aw_n >= rd_done) r6_bad++;
          awq[awq_wp % 8] = m_awaddr;
          awq_wp++;
          aw_n++;
        end
        if (m_wvalid && s_wready) begin
          if (awq_rp == awq_wp) w_bad++;
          else begin
            idx = (int'((awq[awq_rp % 8] - cur_base) >> 6) + wbeat) & 255;
            mem[idx] = m_wdata;
            if (m_wstrb != '1 || m_wlast != (wbeat == 63)) w_bad++;
            if (wbeat == 63) begin awq_rp++; wbeat = 0; w_done++; bpend++; end
            else wbeat++;
          end
        end
        if (s_bvalid && m_bready) begin
          bpend--;
          last_b_cyc = cyc;
          b_n++;
        end
      end
      s_bvalid  <= (bpend > 0);
      s_bresp   <= (b_n == cfg_berr) ? 2'b10 : 2'b00;
      s_wready  <= (cfg_thr == 0) || (cyc % cfg_thr != 0);
      s_awready <= 1'b1;
    end
  end

  // Cycle counter and level monitors
  initial begin
    forever begin
      @(posedge clk);
      cyc <= cyc + 1;
      if (rst_n) begin
        if (in_run && idle && !done) idle_bad++;
        if (done) begin done_cnt++; done_cyc = cyc; in_run = 0; end
      end
    end
  end

  task automatic run_vec(input vec_t v, input int k);
    int t, bad;
    logic [31:0] w;
    bit exp_err;
    for (int i = 0; i < 256; i++) begin
      for (int l = 0; l < 16; l++) begin
        w = ((i * 16 + l) == 37) ? 32'hFFFF_FFFF : (v.seed ^ (32'(i * 16 + l) * 32'h0101_0101));
        orig[i][l*32 +: 32] = w;
      end
      mem[i] = orig[i];
    end
    cur_base = v.base; cfg_thr = int'(v.thr); cfg_rdelay = int'(v.rdelay);
    cfg_rerr = int'(v.rerr); cfg_berr = int'(v.berr);
    ar_n = 0; aw_n = 0; rd_done = 0; w_done = 0; b_n = 0; ar_bad = 0; aw_bad = 0;
    w_bad = 0; r5_bad = 0; r6_bad = 0; ar_before_r = 0; seen_r = 0; done_cnt = 0;
    idle_bad = 0; arq_wp = 0; arq_rp = 0; rbeat = 0; awq_wp = 0; awq_rp = 0;
    wbeat = 0; bpend = 0;
    exp_err = (v.rerr < 3'd4) || (v.berr < 3'd4);

    @(negedge clk); start = 1; base_addr = v.base;
    @(negedge clk); start = 0; base_addr = ~v.base; in_run = 1;
    check(idle == 0, $sformatf("R9 vec%0d idle after start", k), 64'(idle), 64'd0);
    if (prev_err) check(err == 0, $sformatf("R10 vec%0d err cleared by start", k), 64'(err), 64'd0);
    if (v.poke) begin
      repeat (10) @(negedge clk);
      start = 1; base_addr = v.base ^ 64'h0001_0000;
      @(negedge clk); start = 0;
    end
    t = 0;
    while (done_cnt == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);

    bad = 0;
    for (int i = 0; i < 256; i++)
      for (int l = 0; l < 16; l++)
        if (mem[i][l*32 +: 32] != orig[i][l*32 +: 32] + 32'd1) bad++;
    check(bad == 0, $sformatf("R4 vec%0d lanes not incremented", k), 64'(bad), 64'd0);
    check(ar_bad == 0 && ar_n == 4, $sformatf("R2 vec%0d read requests bad/count", k), 64'(ar_bad), 64'd0);
    check(aw_bad == 0 && aw_n == 4, $sformatf("R2 vec%0d write requests bad/count", k), 64'(aw_bad), 64'd0);
    check(w_bad == 0 && w_done == 4, $sformatf("R3 vec%0d write beats bad", k), 64'(w_bad), 64'd0);
    check(r5_bad == 0, $sformatf("R5 vec%0d read issued without space", k), 64'(r5_bad), 64'd0);
    check(r6_bad == 0, $sformatf("R6 vec%0d write issued before data", k), 64'(r6_bad), 64'd0);
    check(done_cnt == 1, $sformatf("R8 vec%0d done pulses", k), 64'(done_cnt), 64'd1);
    check(done_cyc == last_b_cyc + 1, $sformatf("R8 vec%0d done cycle", k), 64'(done_cyc), 64'(last_b_cyc + 1));
    check(idle_bad == 0 && idle == 1, $sformatf("R9 vec%0d idle during/after run", k), 64'(idle_bad), 64'd0);
    check(err == exp_err, $sformatf("R10 vec%0d err flag", k), 64'(err), 64'(exp_err));
    if (v.rdelay > 8'd10)
      check(ar_before_r >= 2, $sformatf("R7 vec%0d reads outstanding before data", k), 64'(ar_before_r), 64'd2);
    prev_err = err;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(idle == 1, "R1 idle after reset", 64'(idle), 64'd1);
    check(done == 0, "R1 done after reset", 64'(done), 64'd0);
    check(err == 0, "R1 err after reset", 64'(err), 64'd0);
    check(!m_arvalid && !m_awvalid && !m_wvalid, "R1 valids after reset",
          64'({m_arvalid, m_awvalid, m_wvalid}), 64'd0);
    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule